// File: doc/BRIEF.md
# Block-Search Tape Motion Controller

This controller positions a block-addressed tape at a requested block before any data moves. A command gives a drive number, a direction and a target block number. The controller selects the drive, starts the tape in the requested direction, waits for the tape to come up to speed, and then compares every block number read from the mark channel against the target. A block short of the target lets the tape run on. A block past the target makes the controller reverse the tape and wait out a turnaround delay. A second reversal brings the tape back so that it arrives at the target moving in the commanded direction. On arrival the controller opens a data-transfer window and pulses a done flag.

The states are IDLE (stopped), SPINUP (up-to-speed delay running), SPDCHK (waiting for the speed-ok input), SEARCH (comparing block numbers), TURN (turnaround delay after a reversal), XFER (transfer window open), COAST (deselected while the tape keeps moving) and FAULT (too many blocks seen without arriving). The transitions are: any state to IDLE on stop. Any state to SPINUP on a command, or to SEARCH when the command reselects a coasting drive in its current direction. An active state to COAST on deselect. SPINUP to SPDCHK when the delay expires. SPDCHK to SEARCH on speed-ok. SEARCH to XFER on arrival, to TURN on overshoot, and to FAULT at the block limit. TURN to SPDCHK when the tape again runs in the commanded direction, and otherwise to SEARCH.

Top module: `blksrch_ctrl`

## Requirements
- R1: During and after reset, with no command, go_o=0, stop_o=1, fwd_o=0, rev_o=0, sel_o=0, all four motor outputs are 0, and xfer_o, done_o and err_o are 0.
- R2: In the cycle after a command (cmd_valid=1), sel_o has exactly bit cmd_drive set, go_o=1, stop_o=0, and the requested direction line is 1 while the other is 0 (cmd_dir 0 = forward, in which block numbers increase; 1 = reverse).
- R3: The motion flip-flop sets only in a cycle where go is asserted and the drive is selected, one cycle after selection. While it is set, the leading motor gets run and the trailing motor gets drag: forward gives run_fwd_o=1 and drag_rev_o=1, reverse gives run_rev_o=1 and drag_fwd_o=1. The two run outputs are never 1 together.
- R4: After a fresh command, block numbers are ignored for SPIN_CYC cycles and then until speed_ok=1. With speed_ok held at 1, the first block that counts is the one sampled SPIN_CYC+2 edges after the command edge.
- R5: While moving in the commanded direction, a block short of the target (smaller for forward, larger for reverse) leaves the motion unchanged. A block equal to the target opens xfer_o and raises done_o in the next cycle.
- R6: While moving in the commanded direction, a block past the target swaps fwd_o and rev_o in the next cycle, and blocks are ignored for the TURN_CYC cycles that follow.
- R7: While moving against the commanded direction, a block short of the target (in the current direction) is passed. A block equal to or past it reverses the tape again, and after TURN_CYC cycles and speed_ok the search resumes. Arrival happens only in the commanded direction, after exactly two reversals when the start lies beyond the target and none otherwise.
- R8: Reverse commands behave as the mirror image of forward ones: rev_o leads, and arrival happens with rev_o=1.
- R9: A stop (cmd_stop=1) takes priority over all other inputs. In the next cycle it gives go_o=0, stop_o=1, all motor outputs 0 and xfer_o=0.
- R10: A deselect (cmd_desel=1) while moving clears sel_o but keeps go_o and the motor outputs. A later command to the same drive in the current direction skips the up-to-speed wait, so a matching block sampled at the next edge opens the window.
- R11: If MAX_BLK compared blocks pass without arrival, err_o=1, go_o=0 and sel_o=0 in the next cycle. err_o holds until the next command clears it.
- R12: done_o is high for exactly one cycle per arrival, while xfer_o stays high until a stop or a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a new positioning command |
| cmd_drive | input | DRV_W | Drive number of the command |
| cmd_dir | input | 1 | Commanded direction, 0 forward, 1 reverse |
| cmd_block | input | BLK_W | Target block number |
| cmd_stop | input | 1 | Stop motion immediately |
| cmd_desel | input | 1 | Deselect the drive while letting the tape coast |
| speed_ok | input | 1 | Tape speed matches the reference |
| blk_valid | input | 1 | A block number was decoded this cycle |
| blk_num | input | BLK_W | Decoded block number |
| sel_o | output | N_DRIVES | One-hot drive select |
| go_o | output | 1 | Go line to the drive |
| stop_o | output | 1 | Stop line to the drive |
| fwd_o | output | 1 | Forward direction line |
| rev_o | output | 1 | Reverse direction line |
| run_fwd_o | output | 1 | Run command to the forward motor |
| drag_fwd_o | output | 1 | Tension command to the forward motor |
| run_rev_o | output | 1 | Run command to the reverse motor |
| drag_rev_o | output | 1 | Tension command to the reverse motor |
| xfer_o | output | 1 | Data-transfer window open |
| done_o | output | 1 | One-cycle arrival pulse |
| err_o | output | 1 | Block-limit timeout |

## Verification
Each control result shows one edge after the input that caused it: select, go and the direction lines after a command, the reversal after an overshooting block, the window and done pulse after a matching block, and the dropped go after a stop or timeout. The motor outputs lag the go line by one more edge, because the motion flip-flop sits between them. The bench drives every stimulus on a falling edge and reads the outputs on the next falling edge, so each check lands in the exact cycle the result is due. For the spin-up and turnaround windows it counts edges, placing blocks one edge inside and one edge outside each window. A sweep over all start and target pairs in both directions runs a tape model that steps block numbers along with the direction lines. For each pair it compares the arrival block, the final direction and the number of reversals against values computed from the start and target.

// File: rtl/blksrch_pkg.sv
package blksrch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SPINUP = 3'd1,
        ST_SPDCHK = 3'd2,
        ST_SEARCH = 3'd3,
        ST_TURN   = 3'd4,
        ST_XFER   = 3'd5,
        ST_COAST  = 3'd6,
        ST_FAULT  = 3'd7
    } mot_state_e;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } tape_dir_e;

    function automatic tape_dir_e flip_dir(input tape_dir_e d);
        return (d == DIR_FWD) ? DIR_REV : DIR_FWD;
    endfunction

endpackage

// File: rtl/blksrch_timer.sv
// Down-counter shared by the up-to-speed and turnaround waits.
module blksrch_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/blksrch_cmp.sv
// Relates an incoming block number to the target along the current motion.
module blksrch_cmp
    import blksrch_pkg::*;
#(
    parameter int BLK_W = 10
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [BLK_W-1:0] tgt,
    input  tape_dir_e        dir_now,
    output logic             is_eq,
    output logic             is_before
);

    assign is_eq = (blk == tgt);

    always_comb begin
        if (dir_now == DIR_FWD) begin
            is_before = (blk < tgt);
        end else begin
            is_before = (blk > tgt);
        end
    end

endmodule

// File: rtl/blksrch_lim.sv
// Counts compared blocks since the last command and flags the last allowed one.
module blksrch_lim #(
    parameter int MAX_BLK = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int CNW = (MAX_BLK > 2) ? $clog2(MAX_BLK) : 1;
    localparam logic [CNW-1:0] LAST = CNW'(MAX_BLK - 1);

    logic [CNW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == LAST);

endmodule

// File: rtl/blksrch_drive.sv
// Drive select decode, motion flip-flop and run/drag motor commands.
module blksrch_drive
    import blksrch_pkg::*;
#(
    parameter int N_DRIVES = 8,
    localparam int DRV_W = $clog2(N_DRIVES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_en,
    input  logic [DRV_W-1:0]    drv_idx,
    input  logic                go_req,
    input  tape_dir_e           dir_now,
    output logic [N_DRIVES-1:0] sel,
    output logic                run_fwd,
    output logic                drag_fwd,
    output logic                run_rev,
    output logic                drag_rev
);

    logic moving_q;
    logic motor_on;

    for (genvar i = 0; i < N_DRIVES; i++) begin : g_sel
        assign sel[i] = sel_en && (drv_idx == DRV_W'(i));
    end

    // Set only while selected with go asserted; held while go stays up.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            moving_q <= 1'b0;
        end else begin
            moving_q <= go_req && (moving_q || sel_en);
        end
    end

    assign motor_on = moving_q && go_req;
    assign run_fwd  = motor_on && (dir_now == DIR_FWD);
    assign drag_rev = motor_on && (dir_now == DIR_FWD);
    assign run_rev  = motor_on && (dir_now == DIR_REV);
    assign drag_fwd = motor_on && (dir_now == DIR_REV);

endmodule

// File: rtl/blksrch_ctrl.sv
module blksrch_ctrl
    import blksrch_pkg::*;
#(
    parameter int N_DRIVES = 8,
    parameter int BLK_W    = 10,
    parameter int SPIN_CYC = 64,
    parameter int TURN_CYC = 32,
    parameter int MAX_BLK  = 1024,
    localparam int DRV_W   = $clog2(N_DRIVES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [DRV_W-1:0]    cmd_drive,
    input  logic                cmd_dir,
    input  logic [BLK_W-1:0]    cmd_block,
    input  logic                cmd_stop,
    input  logic                cmd_desel,
    input  logic                speed_ok,
    input  logic                blk_valid,
    input  logic [BLK_W-1:0]    blk_num,
    output logic [N_DRIVES-1:0] sel_o,
    output logic                go_o,
    output logic                stop_o,
    output logic                fwd_o,
    output logic                rev_o,
    output logic                run_fwd_o,
    output logic                drag_fwd_o,
    output logic                run_rev_o,
    output logic                drag_rev_o,
    output logic                xfer_o,
    output logic                done_o,
    output logic                err_o
);

    localparam int MAXD = (SPIN_CYC > TURN_CYC) ? SPIN_CYC : TURN_CYC;
    localparam int TCW  = $clog2(MAXD + 1);
    localparam logic [TCW-1:0] SPIN_LD = TCW'(SPIN_CYC - 1);
    localparam logic [TCW-1:0] TURN_LD = TCW'(TURN_CYC - 1);

    mot_state_e        state_q, nxt;
    tape_dir_e         dir_q, dir_d;
    tape_dir_e         cdir_q;
    tape_dir_e         cmd_dir_e;
    logic [BLK_W-1:0]  tgt_q;
    logic [DRV_W-1:0]  drv_q;
    logic              done_q;

    logic              tmr_load;
    logic [TCW-1:0]    tmr_val;
    logic              tmr_zero;
    logic              cnt_clr;
    logic              cnt_inc;
    logic              at_limit;
    logic              is_eq;
    logic              is_before;
    logic              aligned;
    logic              active;
    logic              reselect;
    logic              sel_en;
    logic              go_req;

    assign cmd_dir_e = tape_dir_e'(cmd_dir);
    assign aligned   = (dir_q == cdir_q);
    assign active    = (state_q == ST_SPINUP) || (state_q == ST_SPDCHK) ||
                       (state_q == ST_SEARCH) || (state_q == ST_TURN)   ||
                       (state_q == ST_XFER);
    assign reselect  = (state_q == ST_COAST) && (cmd_drive == drv_q) &&
                       (cmd_dir_e == dir_q);

    blksrch_timer #(.CW(TCW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    blksrch_cmp #(.BLK_W(BLK_W)) u_cmp (
        .blk       (blk_num),
        .tgt       (tgt_q),
        .dir_now   (dir_q),
        .is_eq     (is_eq),
        .is_before (is_before)
    );

    blksrch_lim #(.MAX_BLK(MAX_BLK)) u_lim (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .at_limit (at_limit)
    );

    // Next-state decision: stop, then command, then deselect, then per-state flow.
    always_comb begin
        nxt      = state_q;
        dir_d    = dir_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        if (cmd_stop) begin
            nxt = ST_IDLE;
        end else if (cmd_valid) begin
            cnt_clr = 1'b1;
            dir_d   = cmd_dir_e;
            if (reselect) begin
                nxt = ST_SEARCH;
            end else begin
                nxt      = ST_SPINUP;
                tmr_load = 1'b1;
                tmr_val  = SPIN_LD;
            end
        end else if (cmd_desel && active) begin
            nxt = ST_COAST;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_XFER, ST_COAST, ST_FAULT: begin
                    nxt = state_q;
                end
                ST_SPINUP: begin
                    if (tmr_zero) nxt = ST_SPDCHK;
                end
                ST_SPDCHK: begin
                    if (speed_ok) nxt = ST_SEARCH;
                end
                ST_TURN: begin
                    if (tmr_zero) nxt = aligned ? ST_SPDCHK : ST_SEARCH;
                end
                ST_SEARCH: begin
                    if (blk_valid) begin
                        if (aligned && is_eq) begin
                            nxt = ST_XFER;
                        end else if (at_limit) begin
                            nxt = ST_FAULT;
                        end else if (is_before) begin
                            cnt_inc = 1'b1;
                        end else begin
                            cnt_inc  = 1'b1;
                            nxt      = ST_TURN;
                            dir_d    = flip_dir(dir_q);
                            tmr_load = 1'b1;
                            tmr_val  = TURN_LD;
                        end
                    end
                end
            endcase
        end
    end

    // State register and command capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_FWD;
            cdir_q  <= DIR_FWD;
            tgt_q   <= '0;
            drv_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= nxt;
            dir_q   <= dir_d;
            done_q  <= (nxt == ST_XFER) && (state_q != ST_XFER);
            if (cmd_valid && !cmd_stop) begin
                cdir_q <= cmd_dir_e;
                tgt_q  <= cmd_block;
                drv_q  <= cmd_drive;
            end
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        sel_en = 1'b0;
        go_req = 1'b0;
        xfer_o = 1'b0;
        err_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SPINUP, ST_SPDCHK, ST_SEARCH, ST_TURN: begin
                sel_en = 1'b1;
                go_req = 1'b1;
            end
            ST_XFER: begin
                sel_en = 1'b1;
                go_req = 1'b1;
                xfer_o = 1'b1;
            end
            ST_COAST: begin
                go_req = 1'b1;
            end
            ST_FAULT: begin
                err_o = 1'b1;
            end
        endcase
        go_o   = go_req;
        stop_o = !go_req;
        fwd_o  = go_req && (dir_q == DIR_FWD);
        rev_o  = go_req && (dir_q == DIR_REV);
        done_o = done_q;
    end

    blksrch_drive #(.N_DRIVES(N_DRIVES)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_en   (sel_en),
        .drv_idx  (drv_q),
        .go_req   (go_req),
        .dir_now  (dir_q),
        .sel      (sel_o),
        .run_fwd  (run_fwd_o),
        .drag_fwd (drag_fwd_o),
        .run_rev  (run_rev_o),
        .drag_rev (drag_rev_o)
    );

endmodule

// File: rtl/blksrch_chk.sv
module blksrch_chk #(
    parameter int N_DRIVES = 8,
    parameter int BLK_W    = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_dir,
    input logic                cmd_stop,
    input logic                cmd_desel,
    input logic                blk_valid,
    input logic [N_DRIVES-1:0] sel_o,
    input logic                go_o,
    input logic                stop_o,
    input logic                fwd_o,
    input logic                rev_o,
    input logic                run_fwd_o,
    input logic                drag_fwd_o,
    input logic                run_rev_o,
    input logic                drag_rev_o,
    input logic                xfer_o,
    input logic                done_o,
    input logic                err_o
);

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    // R2
    cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_stop) |=> (go_o && !stop_o &&
            (rev_o == $past(cmd_dir)) && (fwd_o != $past(cmd_dir))));

    // R3
    run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_fwd_o && run_rev_o));

    // R3
    run_drag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_fwd_o == drag_rev_o) && (run_rev_o == drag_fwd_o));

    // R5
    window_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_o) |-> $past(blk_valid));

    // R5
    done_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> xfer_o);

    // R9
    stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (stop_o && !go_o && !xfer_o && !run_fwd_o &&
            !run_rev_o && !drag_fwd_o && !drag_rev_o));

    // R10
    desel_coast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_desel && go_o && !cmd_valid && !cmd_stop) |=>
            (go_o && (sel_o == '0)));

    // R11
    fault_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!go_o && (sel_o == '0)));

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind blksrch_ctrl blksrch_chk #(.N_DRIVES(N_DRIVES), .BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_dir    (cmd_dir),
    .cmd_stop   (cmd_stop),
    .cmd_desel  (cmd_desel),
    .blk_valid  (blk_valid),
    .sel_o      (sel_o),
    .go_o       (go_o),
    .stop_o     (stop_o),
    .fwd_o      (fwd_o),
    .rev_o      (rev_o),
    .run_fwd_o  (run_fwd_o),
    .drag_fwd_o (drag_fwd_o),
    .run_rev_o  (run_rev_o),
    .drag_rev_o (drag_rev_o),
    .xfer_o     (xfer_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/tb_blksrch_ctrl.sv
module tb_blksrch_ctrl;

    localparam int ND   = 4;
    localparam int BW   = 3;
    localparam int SPIN = 4;
    localparam int TURN = 3;
    localparam int MAXB = 32;
    localparam int PER  = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          cmd_valid, cmd_dir, cmd_stop, cmd_desel, speed_ok;
    logic [1:0]    cmd_drive;
    logic [BW-1:0] cmd_block;
    logic          blk_valid;
    logic [BW-1:0] blk_num;
    logic [ND-1:0] sel_o;
    logic go_o, stop_o, fwd_o, rev_o, run_fwd_o, drag_fwd_o, run_rev_o, drag_rev_o;
    logic xfer_o, done_o, err_o;

    logic          tape_on;
    logic          man_valid, mdl_valid;
    logic [BW-1:0] man_num, mdl_num;
    int            start_pos, pos, tick, rev_cnt, last_blk;
    bit            fresh, prev_rev;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    assign blk_valid = tape_on ? mdl_valid : man_valid;
    assign blk_num   = tape_on ? mdl_num   : man_num;

    blksrch_ctrl #(
        .N_DRIVES(ND), .BLK_W(BW), .SPIN_CYC(SPIN), .TURN_CYC(TURN), .MAX_BLK(MAXB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_drive(cmd_drive),
        .cmd_dir(cmd_dir), .cmd_block(cmd_block), .cmd_stop(cmd_stop),
        .cmd_desel(cmd_desel), .speed_ok(speed_ok), .blk_valid(blk_valid),
        .blk_num(blk_num), .sel_o(sel_o), .go_o(go_o), .stop_o(stop_o),
        .fwd_o(fwd_o), .rev_o(rev_o), .run_fwd_o(run_fwd_o), .drag_fwd_o(drag_fwd_o),
        .run_rev_o(run_rev_o), .drag_rev_o(drag_rev_o), .xfer_o(xfer_o),
        .done_o(done_o), .err_o(err_o)
    );

    // Tape model: one block every PER cycles while go is up, stepping with rev_o.
    always @(negedge clk) begin
        if (!tape_on || !go_o) begin
            pos = start_pos; tick = 0; rev_cnt = 0; fresh = 1; mdl_valid = 0;
        end else begin
            if (fresh) begin
                prev_rev = rev_o; fresh = 0;
            end else if (rev_o != prev_rev) begin
                rev_cnt++; prev_rev = rev_o; tick = 0;
            end
            mdl_valid = 0;
            tick++;
            if (tick >= PER) begin
                tick = 0;
                if (pos >= 0 && pos < (1 << BW)) begin
                    mdl_valid = 1; mdl_num = BW'(pos); last_blk = pos;
                end
                pos = rev_o ? pos - 1 : pos + 1;
            end
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        finished = 1;
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic eqc(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input int drv, input bit dir, input int tgt);
        cmd_valid = 1; cmd_drive = 2'(drv); cmd_dir = dir; cmd_block = BW'(tgt);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic pulse_blk(input int n);
        man_valid = 1; man_num = BW'(n);
        @(negedge clk);
        man_valid = 0;
    endtask

    task automatic pulse_stop();
        cmd_stop = 1;
        @(negedge clk);
        cmd_stop = 0;
    endtask

    task automatic pulse_desel();
        cmd_desel = 1;
        @(negedge clk);
        cmd_desel = 0;
    endtask

    initial begin
        rst_n = 0; cmd_valid = 0; cmd_drive = 0; cmd_dir = 0; cmd_block = 0;
        cmd_stop = 0; cmd_desel = 0; speed_ok = 0; tape_on = 0;
        man_valid = 0; man_num = 0; start_pos = 0; last_blk = -1;
        idle(3);
        // R1 during reset
        eqc("R1", "go in reset", go_o, 0);
        eqc("R1", "stop in reset", stop_o, 1);
        rst_n = 1;
        idle(1);
        // R1 after reset
        eqc("R1", "sel idle", sel_o, 0);
        eqc("R1", "dir lines idle", {fwd_o, rev_o}, 0);
        eqc("R1", "motors idle", {run_fwd_o, drag_fwd_o, run_rev_o, drag_rev_o}, 0);
        eqc("R1", "flags idle", {xfer_o, done_o, err_o}, 0);

        // R2 / R3 / R4: start, motion latch, speed wait
        send_cmd(2, 0, 5);
        eqc("R2", "sel onehot", sel_o, 4);
        eqc("R2", "go/stop", {go_o, stop_o}, 2);
        eqc("R2", "fwd/rev", {fwd_o, rev_o}, 2);
        eqc("R3", "motion not yet latched", run_fwd_o, 0);
        idle(1);
        eqc("R3", "fwd run, rev drag", {run_fwd_o, drag_fwd_o, run_rev_o, drag_rev_o}, 4'b1001);
        pulse_blk(5);
        eqc("R4", "block in spin-up ignored", done_o, 0);
        idle(4);
        pulse_blk(5);
        eqc("R4", "block without speed ignored", {done_o, xfer_o}, 0);
        speed_ok = 1;
        idle(1);
        pulse_blk(5);
        eqc("R5", "arrival window", {done_o, xfer_o}, 3);
        idle(1);
        eqc("R12", "done single cycle, window held", {done_o, xfer_o}, 1);
        pulse_stop();
        eqc("R9", "stop lines", {go_o, stop_o, xfer_o}, 3'b010);
        eqc("R9", "motors off", {run_fwd_o, drag_fwd_o, run_rev_o, drag_rev_o}, 0);

        // R4 exact boundary with speed already ok
        send_cmd(0, 0, 3);
        idle(4);
        pulse_blk(3);
        eqc("R4", "block at SPIN+1 ignored", done_o, 0);
        pulse_blk(3);
        eqc("R4", "block at SPIN+2 counts", done_o, 1);
        pulse_stop();

        // R6 / R7: overshoot, turnaround, return
        send_cmd(1, 0, 5);
        idle(5);
        pulse_blk(3);
        eqc("R5", "short block keeps forward", {fwd_o, rev_o, done_o}, 3'b100);
        pulse_blk(6);
        eqc("R6", "overshoot reverses", {fwd_o, rev_o}, 1);
        pulse_blk(4);
        eqc("R6", "block in turnaround ignored", {fwd_o, rev_o}, 1);
        idle(2);
        pulse_blk(7);
        eqc("R7", "against-search passes short block", {fwd_o, rev_o}, 1);
        pulse_blk(5);
        eqc("R7", "target against command turns back", {fwd_o, rev_o, done_o}, 3'b100);
        pulse_blk(5);
        eqc("R7", "no arrival during turnaround", done_o, 0);
        idle(3);
        pulse_blk(5);
        eqc("R7", "arrival after second turn", {done_o, xfer_o, fwd_o}, 3'b111);
        pulse_stop();

        // R8 mirror
        send_cmd(3, 1, 2);
        eqc("R8", "reverse start", {sel_o, fwd_o, rev_o}, {4'b1000, 2'b01});
        idle(6);
        eqc("R8", "reverse motors", {run_fwd_o, drag_fwd_o, run_rev_o, drag_rev_o}, 4'b0110);
        pulse_blk(4);
        eqc("R8", "larger block short in reverse", {fwd_o, rev_o, done_o}, 3'b010);
        pulse_blk(1);
        eqc("R8", "smaller block overshoots", {fwd_o, rev_o}, 2);
        pulse_stop();

        // R10 deselect and reselect
        send_cmd(1, 0, 5);
        idle(5);
        pulse_blk(2);
        pulse_desel();
        eqc("R10", "deselected", sel_o, 0);
        eqc("R10", "still moving", {go_o, run_fwd_o}, 3);
        idle(3);
        eqc("R10", "coasting holds", {go_o, run_fwd_o}, 3);
        send_cmd(1, 0, 6);
        eqc("R10", "reselected", sel_o, 2);
        pulse_blk(6);
        eqc("R10", "immediate arrival", {done_o, xfer_o}, 3);
        pulse_stop();

        // R11 block limit
        send_cmd(0, 0, 7);
        idle(5);
        repeat (MAXB - 1) pulse_blk(0);
        eqc("R11", "below limit", {err_o, go_o}, 1);
        pulse_blk(0);
        eqc("R11", "limit fault", {err_o, go_o, stop_o}, 3'b101);
        eqc("R11", "fault deselects", sel_o, 0);
        idle(3);
        eqc("R11", "fault holds", err_o, 1);
        send_cmd(0, 0, 7);
        eqc("R11", "command clears fault", {err_o, go_o}, 1);
        pulse_stop();

        // Sweep: all start/target pairs, both directions, through the tape model
        tape_on = 1;
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < (1 << BW); s++) begin
                for (int t = 0; t < (1 << BW); t++) begin
                    bit got;
                    int exp_rev, drv;
                    string req;
                    req = (d == 1) ? "R8" : "R7";
                    drv = (s + t) % ND;
                    exp_rev = (d == 0) ? ((s <= t) ? 0 : 2) : ((s >= t) ? 0 : 2);
                    start_pos = s;
                    idle(2);
                    send_cmd(drv, d[0], t);
                    got = 0;
                    for (int k = 0; k < 1500 && !got; k++) begin
                        @(negedge clk); #2;
                        if (done_o) got = 1;
                    end
                    eqc("R5", "arrived", got, 1);
                    eqc(req, "arrival block", last_blk, t);
                    eqc(req, "arrival direction", rev_o, d);
                    eqc(req, "reversal count", rev_cnt, exp_rev);
                    eqc("R2", "drive kept", sel_o, 1 << drv);
                    pulse_stop();
                end
            end
        end
        tape_on = 0;
        idle(2);
        report();
    end

endmodule